// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between memory and peripherals on behalf of the processor. It has four channels. Software sets each one up through a small host write port by loading a start address, a transfer count and a mode word. A peripheral then raises its request line. The controller asks the system for the bus with a hold request. Once the bus is granted, the controller acknowledges the peripheral and drives a memory address together with a read or a write strobe, one unit per clock.

Each channel keeps the programmed values in base registers and steps working copies of them as data moves. The mode word picks one of three service styles. In single mode the channel moves one unit and hands the bus back. In block mode it keeps the bus until its count runs out. In cascade mode it only forwards the handshake to a second controller further down the chain. The mode word also sets the transfer direction and whether the address counts up or down. It can also make the channel reload itself when it finishes, so that it serves a repeating stream. When a count runs out, the block pulses a terminal-count line, latches a per-channel done flag and raises an interrupt.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold_req, dack, mem_rd, mem_wr, tc and irq are all 0. chan_mask reads 4'b1111 and chan_done reads 4'b0000.
- R2: A host write with reg_sel=0 loads the channel's base and current address from reg_wdata. reg_sel=1 loads the base and current count. reg_sel=2 loads the mode word. reg_sel=3 sets the mask bit to reg_wdata[0] and clears the done flag when reg_wdata[1] is 1. The first transfer after programming uses the written address.
- R3: dack is at most one-hot. A channel's dack is asserted only while hold_ack is high, and hold_req is raised before any dack.
- R4: Among unmasked channels with dreq high, the lowest channel number is served first.
- R5: In single mode each bus grant (a rise of hold_req) carries exactly one transfer, and hold_req drops after it.
- R6: In block mode the channel keeps the bus for its whole count, and a higher-priority request arriving meanwhile waits until the block ends.
- R7: A count value of N-1 gives N transfers. tc pulses together with the strobe of the last one, and that channel's chan_done bit is set.
- R8: Without auto-reload, reaching terminal count sets the channel's mask bit, and further dreq on that channel is ignored (no hold_req, no strobes).
- R9: With auto-reload (mode bit 4), terminal count reloads address and count from the base registers and the channel stays unmasked, so the address pattern repeats.
- R10: Mode bit 2 = 0 gives mem_rd (memory to peripheral) and 1 gives mem_wr (peripheral to memory), never both at once. Mode bit 3 = 0 increments the address per transfer and 1 decrements it.
- R11: Mode bits [1:0] select the service style: 0 single, 1 block, 2 cascade. A cascade channel holds dack and hold_req while its dreq stays high, drives no strobes, and releases both once dreq falls.
- R12: irq is high exactly while any chan_done bit is set, and a control write with reg_wdata[1]=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe |
| reg_ch | input | 2 | Channel selected by the host write |
| reg_sel | input | 2 | Register selected: 0 address, 1 count, 2 mode, 3 control |
| reg_wdata | input | 16 | Host write data |
| dreq | input | 4 | Peripheral request lines, one per channel |
| hold_ack | input | 1 | Bus granted to the controller |
| hold_req | output | 1 | Controller asks for the bus |
| dack | output | 4 | Peripheral acknowledge lines, one per channel |
| mem_addr | output | 16 | Memory address during a transfer, 0 otherwise |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| tc | output | 1 | Terminal-count pulse on a channel's last transfer |
| irq | output | 1 | Completion interrupt |
| chan_mask | output | 4 | Per-channel mask bits |
| chan_done | output | 4 | Per-channel terminal-count flags |

## Verification
A block transfer on a single channel checks counting, strobes and masking in isolation. A repeating single-mode channel with a decrementing address and auto-reload separates reload from re-masking, and it also separates one grant per unit from bus retention. Pairs of channels asserted on the same edge, in directed and randomly chosen combinations of mode, direction and count, show whether arbitration favours the lower number. A late high-priority request during a block shows whether the block is wrongly preempted. A cascade channel held for several cycles separates pure handshake forwarding from real transfers.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

   // Service styles held in mode bits [1:0]
   localparam logic [1:0] XT_SINGLE  = 2'd0;
   localparam logic [1:0] XT_BLOCK   = 2'd1;
   localparam logic [1:0] XT_CASCADE = 2'd2;

   // Host register selectors
   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_MODE  = 2'd2;
   localparam logic [1:0] SEL_CTRL  = 2'd3;

   // Mode word: bit4 auto-reload, bit3 decrement, bit2 peripheral-to-memory, [1:0] style
   typedef struct packed {
      logic       auto_rl;
      logic       addr_dec;
      logic       to_mem;
      logic [1:0] xtype;
   } chan_mode_t;

   localparam int MODE_W = $bits(chan_mode_t);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HOLD,
      ST_XFER,
      ST_CASC
   } seq_state_e;

endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
   parameter int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] idx
);

   // Fixed priority: lowest index wins, so scan from the top down
   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) idx = CHW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
   import dma4_pkg::*;
#(
   parameter int AW       = 16,
   parameter int CW       = 16,
   parameter int DW       = 16,
   parameter bit HAS_AUTO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          step,
   output logic [AW-1:0] cur_addr,
   output logic          to_mem,
   output logic [1:0]    xtype,
   output logic          mask,
   output logic          done,
   output logic          last
);

   logic [AW-1:0] base_addr;
   logic [CW-1:0] base_cnt;
   logic [CW-1:0] cur_cnt;
   chan_mode_t    mode;
   logic          reload_en;
   logic [AW-1:0] next_addr;

   // Variant: reload hardware present or tied off
   generate
      if (HAS_AUTO) begin : g_reload
         assign reload_en = mode.auto_rl;
      end else begin : g_noreload
         assign reload_en = 1'b0;
      end
   endgenerate

   assign next_addr = mode.addr_dec ? cur_addr - AW'(1) : cur_addr + AW'(1);
   assign last      = (cur_cnt == '0);
   assign to_mem    = mode.to_mem;
   assign xtype     = mode.xtype;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
         mode      <= '0;
         mask      <= 1'b1;
         done      <= 1'b0;
      end else begin
         if (step) begin
            if (last) begin
               done <= 1'b1;
               if (reload_en) begin
                  cur_addr <= base_addr;
                  cur_cnt  <= base_cnt;
               end else begin
                  mask     <= 1'b1;
                  cur_addr <= next_addr;
                  cur_cnt  <= cur_cnt - CW'(1);
               end
            end else begin
               cur_addr <= next_addr;
               cur_cnt  <= cur_cnt - CW'(1);
            end
         end
         if (wr_en) begin
            case (wr_sel)
               SEL_ADDR: begin
                  base_addr <= wr_data[AW-1:0];
                  cur_addr  <= wr_data[AW-1:0];
               end
               SEL_COUNT: begin
                  base_cnt <= wr_data[CW-1:0];
                  cur_cnt  <= wr_data[CW-1:0];
               end
               SEL_MODE: mode <= chan_mode_t'(wr_data[MODE_W-1:0]);
               default: begin
                  mask <= wr_data[0];
                  if (wr_data[1]) done <= 1'b0;
               end
            endcase
         end
      end
   end

   // R8: terminal count without reload masks the channel
   assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !reload_en && !wr_en) |=> mask);

   // R9: terminal count with reload restores the programmed values and keeps the channel armed
   assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && reload_en && !wr_en) |=>
         (cur_cnt == base_cnt && cur_addr == base_addr && mask == $past(mask)));

   // R7: every finishing step leaves the done flag set
   assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !wr_en) |=> done);

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
   import dma4_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int AW       = 16,
   parameter int CW       = 16,
   parameter int DW       = 16,
   parameter bit HAS_AUTO = 1'b1,
   localparam int CHW     = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [CHW-1:0] reg_ch,
   input  logic [1:0]     reg_sel,
   input  logic [DW-1:0]  reg_wdata,
   input  logic [NCH-1:0] dreq,
   input  logic           hold_ack,
   output logic           hold_req,
   output logic [NCH-1:0] dack,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           tc,
   output logic           irq,
   output logic [NCH-1:0] chan_mask,
   output logic [NCH-1:0] chan_done
);

   // Elaboration-time parameter checks
   generate
      if (NCH < 2 || NCH > 8) begin : g_bad_nch
         $error("dma4_ctrl: NCH must lie in 2..8");
      end
      if (AW > DW || CW > DW || MODE_W > DW) begin : g_bad_dw
         $error("dma4_ctrl: DW must cover AW, CW and the mode word");
      end
   endgenerate

   logic [AW-1:0]  ch_addr [NCH];
   logic [1:0]     ch_xtype[NCH];
   logic [NCH-1:0] ch_tomem;
   logic [NCH-1:0] ch_last;
   logic [NCH-1:0] step_v;
   logic [NCH-1:0] elig;
   logic           arb_any;
   logic [CHW-1:0] arb_idx;

   seq_state_e     state, state_nx;
   logic [CHW-1:0] cur_ch;

   logic [1:0]     sel_xtype;
   logic           sel_last;
   logic           sel_tomem;
   logic           in_xfer;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         dma4_chan #(
            .AW      (AW),
            .CW      (CW),
            .DW      (DW),
            .HAS_AUTO(HAS_AUTO)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && (reg_ch == CHW'(g))),
            .wr_sel  (reg_sel),
            .wr_data (reg_wdata),
            .step    (step_v[g]),
            .cur_addr(ch_addr[g]),
            .to_mem  (ch_tomem[g]),
            .xtype   (ch_xtype[g]),
            .mask    (chan_mask[g]),
            .done    (chan_done[g]),
            .last    (ch_last[g])
         );
         assign step_v[g] = in_xfer && (cur_ch == CHW'(g));
         assign dack[g]   = (state == ST_XFER || state == ST_CASC) && (cur_ch == CHW'(g));
      end
   endgenerate

   assign elig = dreq & ~chan_mask;

   dma4_arb #(.NCH(NCH)) u_arb (
      .req(elig),
      .any(arb_any),
      .idx(arb_idx)
   );

   assign sel_xtype = ch_xtype[cur_ch];
   assign sel_last  = ch_last[cur_ch];
   assign sel_tomem = ch_tomem[cur_ch];
   assign in_xfer   = (state == ST_XFER);

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (arb_any) state_nx = ST_HOLD;
         ST_HOLD: if (hold_ack) state_nx = (sel_xtype == XT_CASCADE) ? ST_CASC : ST_XFER;
         ST_XFER: state_nx = (sel_xtype == XT_BLOCK && !sel_last) ? ST_XFER : ST_IDLE;
         default: if (!dreq[cur_ch]) state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur_ch <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && arb_any) cur_ch <= arb_idx;
      end
   end

   assign hold_req = (state != ST_IDLE);
   assign mem_rd   = in_xfer && !sel_tomem;
   assign mem_wr   = in_xfer && sel_tomem;
   assign mem_addr = in_xfer ? ch_addr[cur_ch] : '0;
   assign tc       = in_xfer && sel_last;
   assign irq      = |chan_done;

   // R3: at most one acknowledge, and only on a granted bus
   assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   assert_dack_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> (hold_ack && hold_req));

   // R10: never both strobes
   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7: terminal count only accompanies a strobed, acknowledged transfer
   assert_tc_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ((mem_rd || mem_wr) && (|dack)));

   // R5: a single-mode transfer gives the bus back on the next cycle
   assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && sel_xtype == XT_SINGLE) |=> !hold_req);

   // R6: an unfinished block keeps the same channel on the bus
   assert_block_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && sel_xtype == XT_BLOCK && !sel_last) |=> (in_xfer && $stable(cur_ch)));

   // R11: cascade service raises no strobes
   assert_cascade_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CASC) |-> !(mem_rd || mem_wr || tc));

endmodule

// File: tb/dma4_ctrl_tb.sv
`timescale 1ns/1ps
module dma4_ctrl_tb;

   localparam int NCH = 4;
   localparam int AW  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_ch = '0;
   logic [1:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [3:0]  dreq = '0;
   logic        hold_ack = 1'b0;
   logic        hold_req;
   logic [3:0]  dack;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, tc, irq;
   logic [3:0]  chan_mask, chan_done;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   dma4_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .dreq(dreq), .hold_ack(hold_ack), .hold_req(hold_req),
      .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc),
      .irq(irq), .chan_mask(chan_mask), .chan_done(chan_done)
   );

   // Bus owner grants the bus one half-cycle after it is asked for
   initial forever begin
      @(negedge clk);
      hold_ack = hold_req;
   end

   // Transfer log and grant counter
   int   log_n = 0;
   int   grants = 0;
   int   log_ch  [0:1023];
   int   log_addr[0:1023];
   bit   log_rd  [0:1023];
   bit   log_tc  [0:1023];
   logic prev_hr = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_req && !prev_hr) grants <= grants + 1;
         if ((mem_rd || mem_wr) && log_n < 1024) begin
            log_ch[log_n] = -1;
            for (int i = 0; i < NCH; i++) if (dack[i]) log_ch[log_n] = i;
            log_addr[log_n] = int'(mem_addr);
            log_rd[log_n]   = mem_rd;
            log_tc[log_n]   = tc;
            log_n <= log_n + 1;
         end
      end
      prev_hr <= hold_req;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(input int ch, input int sel, input int data);
      @(negedge clk);
      reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = 16'(data);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic int mk_mode(bit auto_rl, bit dec, bit to_mem, int xt);
      return (int'(auto_rl) << 4) | (int'(dec) << 3) | (int'(to_mem) << 2) | (xt & 3);
   endfunction

   function automatic int exp_addr(int base, int k, bit dec, int n);
      int off = k % n;
      return dec ? ((base - off) & 16'hFFFF) : ((base + off) & 16'hFFFF);
   endfunction

   task automatic program_ch(input int ch, input int base, input int n, input int mode);
      wr(ch, 0, base);
      wr(ch, 1, n - 1);
      wr(ch, 2, mode);
      wr(ch, 3, 2);              // unmask and clear done
   endtask

   task automatic wait_log(input int target, input int maxc, input string req);
      int c = 0;
      while (log_n < target && c < maxc) begin
         @(negedge clk);
         c++;
      end
      chk(req, "transfers reached in time", longint'(log_n >= target), 1);
   endtask

   task automatic check_run(input int start, input int num, input int ch, input int base,
                            input int n, input bit dec, input bit to_mem, input string req);
      for (int k = 0; k < num; k++) begin
         chk(req, $sformatf("xfer %0d channel", k), log_ch[start + k], ch);
         chk(req, $sformatf("xfer %0d address", k), log_addr[start + k], exp_addr(base, k, dec, n));
         chk("R10", $sformatf("xfer %0d read strobe", k), longint'(log_rd[start + k]), longint'(!to_mem));
         chk("R7", $sformatf("xfer %0d tc", k), longint'(log_tc[start + k]), longint'((k % n) == n - 1));
      end
   endtask

   initial begin
      int st, g0;
      void'($urandom(32'd4711));
      cyc(4);
      rst_n = 1'b1;
      cyc(1);

      // R1: reset state
      chk("R1", "hold_req", hold_req, 0);
      chk("R1", "dack", dack, 0);
      chk("R1", "strobes", {mem_rd, mem_wr, tc}, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "chan_mask", chan_mask, 4'hF);
      chk("R1", "chan_done", chan_done, 0);

      // R2, R6, R7, R8, R10, R12: block, increment, memory read on channel 1
      st = log_n;
      program_ch(1, 16'h0100, 4, mk_mode(0, 0, 0, 1));
      dreq[1] = 1'b1;
      wait_log(st + 4, 200, "R6");
      cyc(3);
      chk("R6", "block transfer count", log_n - st, 4);
      check_run(st, 4, 1, 16'h0100, 4, 0, 0, "R2/R6");
      chk("R7", "done bit 1", chan_done, 4'b0010);
      chk("R12", "irq raised", irq, 1);
      chk("R8", "mask bit 1 after tc", chan_mask[1], 1);
      dreq[1] = 1'b0;
      cyc(2);
      dreq[1] = 1'b1;
      st = log_n;
      cyc(20);
      chk("R8", "masked channel transfers", log_n - st, 0);
      chk("R8", "masked channel hold_req", hold_req, 0);
      dreq[1] = 1'b0;
      wr(1, 3, 3);
      cyc(1);
      chk("R12", "irq cleared", irq, 0);

      // R5, R9, R10: single, decrement, peripheral to memory, auto-reload on channel 2
      program_ch(2, 16'h0200, 2, mk_mode(1, 1, 1, 0));
      st = log_n;
      g0 = grants;
      dreq[2] = 1'b1;
      wait_log(st + 5, 300, "R9");
      dreq[2] = 1'b0;
      cyc(10);
      check_run(st, 5, 2, 16'h0200, 2, 1, 1, "R9");
      chk("R5", "one transfer per grant", grants - g0, log_n - st);
      chk("R9", "channel stays armed", chan_mask[2], 0);
      chk("R12", "irq from reload channel", irq, 1);
      wr(2, 3, 3);

      // R4: channels 0 and 3 raised together
      program_ch(3, 16'h3000, 2, mk_mode(0, 0, 0, 0));
      program_ch(0, 16'h0010, 3, mk_mode(0, 0, 1, 0));
      st = log_n;
      dreq[0] = 1'b1; dreq[3] = 1'b1;
      wait_log(st + 5, 300, "R4");
      cyc(5);
      dreq = '0;
      check_run(st, 3, 0, 16'h0010, 3, 0, 1, "R4");
      check_run(st + 3, 2, 3, 16'h3000, 2, 0, 0, "R4");

      // R6: late channel 0 request waits for channel 2 block
      program_ch(2, 16'h0400, 6, mk_mode(0, 0, 0, 1));
      program_ch(0, 16'h0050, 2, mk_mode(0, 1, 0, 0));
      st = log_n;
      dreq[2] = 1'b1;
      wait_log(st + 1, 50, "R6");
      dreq[0] = 1'b1;
      wait_log(st + 8, 300, "R6");
      cyc(3);
      dreq = '0;
      check_run(st, 6, 2, 16'h0400, 6, 0, 0, "R6");
      check_run(st + 6, 2, 0, 16'h0050, 2, 1, 0, "R6");

      // R3, R11: cascade on channel 1
      program_ch(1, 16'h7777, 1, mk_mode(0, 0, 0, 2));
      st = log_n;
      dreq[1] = 1'b1;
      cyc(1);
      chk("R3", "hold_req before grant", hold_req, 1);
      chk("R3", "no dack before grant", dack, 0);
      cyc(8);
      chk("R11", "cascade dack", dack, 4'b0010);
      chk("R11", "cascade hold_req", hold_req, 1);
      chk("R11", "cascade strobes", log_n - st, 0);
      dreq[1] = 1'b0;
      cyc(3);
      chk("R11", "cascade released dack", dack, 0);
      chk("R11", "cascade released hold", hold_req, 0);
      chk("R11", "cascade no done", chan_done[1], 0);
      wr(1, 3, 1);

      // R4, R7, R10: random channel pairs, styles, directions and counts
      for (int it = 0; it < 6; it++) begin
         int a, b, na, nb, ba, bb, ma, mb;
         bit da, db, ta, tb;
         a  = int'($urandom % 3);
         b  = a + 1 + int'($urandom % (3 - a));
         na = 1 + int'($urandom % 6);  nb = 1 + int'($urandom % 6);
         ba = int'($urandom & 16'hFFFF); bb = int'($urandom & 16'hFFFF);
         da = 1'($urandom); db = 1'($urandom);
         ta = 1'($urandom); tb = 1'($urandom);
         ma = mk_mode(0, da, ta, int'($urandom % 2));
         mb = mk_mode(0, db, tb, int'($urandom % 2));
         program_ch(a, ba, na, ma);
         program_ch(b, bb, nb, mb);
         st = log_n;
         dreq[a] = 1'b1; dreq[b] = 1'b1;
         wait_log(st + na + nb, 400, "R4");
         cyc(5);
         dreq = '0;
         chk("R7", "random total transfers", log_n - st, na + nb);
         check_run(st, na, a, ba, na, da, ta, "R4");
         check_run(st + na, nb, b, bb, nb, db, tb, "R4");
         chk("R8", "random pair masked", {chan_mask[a], chan_mask[b]}, 2'b11);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule